// File: doc/BRIEF.md
# Fixed-Priority Bounded Command Arbiter

This block sits between a set of burst requesters and a shared command queue that can hold only a fixed number of outstanding commands. Each requester can raise a read request and a write request. Each request carries a burst beat count, and that count is fixed when the request is admitted. Two separate fixed-priority arbiters pick one read requester and one write requester. A direction selector then decides which of the two enters the queue, and it enters only if a slot is free.

An admitted command occupies a slot until a completion names that slot. Reads complete when their data returns. Writes are posted, so they complete as soon as their data has been sent. The completion port is the only way a slot is released. A slot may be released and refilled in the same cycle, so a full queue stays full without a bubble.

Top module: `cmd_admit_arbiter`

## Requirements
- R1: Among asserted read requests, the grant goes to the lowest requester index. `rd_gnt` is a one-hot pulse in the same cycle as the request, and it is never given to a requester that is not requesting.
- R2: Write requests are arbitrated by their own fixed-priority picker, which also favours the lowest index. At most one grant is issued per cycle across `rd_gnt` and `wr_gnt` together.
- R3: At most NUM_SLOTS (8) commands are active. When all slots are busy and no completion arrives, no grant is issued.
- R4: When both directions request and a slot is free, the direction not admitted most recently wins. After reset, read is preferred first.
- R5: One cycle after a grant, `cmd_valid` is 1 and the command fields are set. `cmd_id` is the granted index. `cmd_write` is 1 for a write and 0 for a read. `cmd_len` is the requester's beat count. `cmd_slot` is the lowest-numbered free slot. In any cycle after a cycle with no grant, `cmd_valid` is 0.
- R6: A completion with `done_valid` set frees the active slot named by `done_slot`, and `active_cnt` drops by one. A slot freed in a cycle may be taken by an admission in that same cycle, and `active_cnt` is then unchanged.
- R7: A completion naming a slot that is not active sets `err_bad_done`. The flag stays at 1 until reset, and `active_cnt` is left unchanged.
- R8: Synchronous active-low reset clears all slots, `active_cnt`, `err_bad_done` and `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | NUM_REQ | Read request per requester |
| rd_len | input | NUM_REQ*LEN_W | Read beat count per requester |
| wr_req | input | NUM_REQ | Write request per requester |
| wr_len | input | NUM_REQ*LEN_W | Write beat count per requester |
| rd_gnt | output | NUM_REQ | One-cycle read grant |
| wr_gnt | output | NUM_REQ | One-cycle write grant |
| cmd_valid | output | 1 | Command admitted in previous cycle |
| cmd_id | output | ID_W | Requester index of the admitted command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_len | output | LEN_W | Burst beat count |
| cmd_slot | output | SLOT_W | Slot given to the command |
| done_valid | input | 1 | Completion strobe |
| done_slot | input | SLOT_W | Slot being completed |
| active_cnt | output | CNT_W | Number of busy slots |
| err_bad_done | output | 1 | Sticky flag for a completion on an idle slot |

## Verification
The grants are combinational, so they are due in the same cycle as the request and completion inputs that cause them. The command fields, `active_cnt` and the error flag all change at the next rising edge. The bench changes its inputs on the falling edge and reads the grants one nanosecond later, before the rising edge. It reads the registered results one nanosecond after that rising edge, so each result is sampled exactly in the cycle in which it becomes due.

// File: rtl/cmd_arb_pkg.sv
// Package: shared constants and helpers for the command admission arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cmd_arb_pkg;
    // Direction encoding carried with each command (also the cmd_write bit).
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;

    // Width needed to index W items (at least one bit).
    function automatic int idx_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction
endpackage

// File: rtl/prio_pick.sv
// Fixed-priority picker: returns a one-hot grant and the index of the
// lowest-numbered asserted bit. Purely combinational; assumes W >= 1.
module prio_pick #(
    parameter int W = 4,
    localparam int IW = cmd_arb_pkg::idx_width(W)
) (
    input  logic [W-1:0]  req,
    output logic [W-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest asserted index is the last one written.
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/slot_table.sv
// Slot table: one busy bit per queue slot. It frees a slot on a completion,
// allocates the lowest free slot on admission (a slot freed this cycle
// counts as free), reports the active count and keeps a sticky flag for
// completions on idle slots. Assumes at most one admission per cycle.
module slot_table #(
    parameter int NUM_SLOTS = 8,
    localparam int SW = cmd_arb_pkg::idx_width(NUM_SLOTS),
    localparam int CW = $clog2(NUM_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          done_valid,
    input  logic [SW-1:0] done_slot,
    output logic          room,
    output logic [SW-1:0] alloc_slot,
    output logic [CW-1:0] active_cnt,
    output logic          err
);
    logic [NUM_SLOTS-1:0] busy;
    logic [NUM_SLOTS-1:0] clr;
    logic [NUM_SLOTS-1:0] avail;
    logic [NUM_SLOTS-1:0] pick;
    logic                 bad_done;

    // Decode a legal completion into a clear mask and flag an illegal one.
    always_comb begin
        clr      = '0;
        bad_done = 1'b0;
        if (done_valid) begin
            if (busy[done_slot]) clr[done_slot] = 1'b1;
            else                 bad_done       = 1'b1;
        end
        avail = ~busy | clr;
    end

    prio_pick #(.W(NUM_SLOTS)) u_free (
        .req (avail),
        .gnt (pick),
        .any (room),
        .idx (alloc_slot)
    );

    // Update the busy bits: release completed slots, claim the allocated one.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy & ~clr) | (alloc_en ? pick : '0);
    end

    // Hold the error flag once a completion hits an idle slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        err <= 1'b0;
        else if (bad_done) err <= 1'b1;
    end

    assign active_cnt = CW'($countones(busy));
endmodule

// File: rtl/dir_select.sv
// Direction selector: when both read and write have a winner and there is
// room, it alternates, favouring the direction not admitted last.
// Read is favoured after reset.
module dir_select (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_any,
    input  logic wr_any,
    input  logic room,
    output logic take_rd,
    output logic take_wr
);
    logic pref_wr;

    // Decide which direction enters this cycle.
    always_comb begin
        take_rd = room && rd_any && (!wr_any || !pref_wr);
        take_wr = room && wr_any && (!rd_any ||  pref_wr);
    end

    // Turn preference toward the direction just passed over.
    always_ff @(posedge clk) begin
        if (!rst_n)       pref_wr <= 1'b0;
        else if (take_rd) pref_wr <= 1'b1;
        else if (take_wr) pref_wr <= 1'b0;
    end
endmodule

// File: rtl/cmd_admit_arbiter.sv
// Top: admits at most one burst command per cycle into a queue of
// NUM_SLOTS slots. Reads and writes each go through a fixed-priority
// picker (lowest index wins). Grants are same-cycle pulses; the admitted
// command appears registered one cycle later. Assumes each requester
// holds its request until granted and drops it in the following cycle.
module cmd_admit_arbiter #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOTS = 8,
    parameter int LEN_W     = 4,
    localparam int ID_W   = cmd_arb_pkg::idx_width(NUM_REQ),
    localparam int SLOT_W = cmd_arb_pkg::idx_width(NUM_SLOTS),
    localparam int CNT_W  = $clog2(NUM_SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_REQ-1:0]       rd_req,
    input  logic [NUM_REQ*LEN_W-1:0] rd_len,
    input  logic [NUM_REQ-1:0]       wr_req,
    input  logic [NUM_REQ*LEN_W-1:0] wr_len,
    output logic [NUM_REQ-1:0]       rd_gnt,
    output logic [NUM_REQ-1:0]       wr_gnt,
    output logic                     cmd_valid,
    output logic [ID_W-1:0]          cmd_id,
    output logic                     cmd_write,
    output logic [LEN_W-1:0]         cmd_len,
    output logic [SLOT_W-1:0]        cmd_slot,
    input  logic                     done_valid,
    input  logic [SLOT_W-1:0]        done_slot,
    output logic [CNT_W-1:0]         active_cnt,
    output logic                     err_bad_done
);
    import cmd_arb_pkg::*;

    logic [NUM_REQ-1:0] rd_win, wr_win;
    logic               rd_any, wr_any;
    logic [ID_W-1:0]    rd_idx, wr_idx;
    logic               take_rd, take_wr, room;
    logic [SLOT_W-1:0]  alloc_slot;

    prio_pick #(.W(NUM_REQ)) u_rd_pick (
        .req (rd_req), .gnt (rd_win), .any (rd_any), .idx (rd_idx)
    );

    prio_pick #(.W(NUM_REQ)) u_wr_pick (
        .req (wr_req), .gnt (wr_win), .any (wr_any), .idx (wr_idx)
    );

    dir_select u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_any  (rd_any),
        .wr_any  (wr_any),
        .room    (room),
        .take_rd (take_rd),
        .take_wr (take_wr)
    );

    slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (take_rd || take_wr),
        .done_valid (done_valid),
        .done_slot  (done_slot),
        .room       (room),
        .alloc_slot (alloc_slot),
        .active_cnt (active_cnt),
        .err        (err_bad_done)
    );

    // Gate each picker's winner with the direction decision.
    always_comb begin
        rd_gnt = take_rd ? rd_win : '0;
        wr_gnt = take_wr ? wr_win : '0;
    end

    // Register the admitted command with its id, direction, length and slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_id    <= '0;
            cmd_write <= DIR_READ;
            cmd_len   <= '0;
            cmd_slot  <= '0;
        end else begin
            cmd_valid <= take_rd || take_wr;
            if (take_wr) begin
                cmd_id    <= wr_idx;
                cmd_write <= DIR_WRITE;
                cmd_len   <= wr_len[wr_idx*LEN_W +: LEN_W];
                cmd_slot  <= alloc_slot;
            end else if (take_rd) begin
                cmd_id    <= rd_idx;
                cmd_write <= DIR_READ;
                cmd_len   <= rd_len[rd_idx*LEN_W +: LEN_W];
                cmd_slot  <= alloc_slot;
            end
        end
    end
endmodule

// File: rtl/cmd_admit_arbiter_chk.sv
// Checker for cmd_admit_arbiter: relates grants, command outputs,
// count and error flag over time. Attached by bind below.
module cmd_admit_arbiter_chk #(
    parameter int NUM_REQ   = 4,
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3,
    parameter int CNT_W     = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] rd_req,
    input logic [NUM_REQ-1:0] wr_req,
    input logic [NUM_REQ-1:0] rd_gnt,
    input logic [NUM_REQ-1:0] wr_gnt,
    input logic               cmd_valid,
    input logic               done_valid,
    input logic [CNT_W-1:0]   active_cnt,
    input logic               err_bad_done
);
    logic any_gnt;
    assign any_gnt = (|rd_gnt) || (|wr_gnt);

    // R1
    rd_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt & ~rd_req) == '0);

    // R2
    single_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_gnt, wr_gnt}) && ((wr_gnt & ~wr_req) == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_cnt == CNT_W'(NUM_SLOTS) && !done_valid) |-> !any_gnt);

    // R5
    cmd_follows_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt |=> cmd_valid);

    // R6
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && !done_valid) |=> active_cnt == $past(active_cnt) + 1'b1);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_bad_done) |-> $past(done_valid));
endmodule

bind cmd_admit_arbiter cmd_admit_arbiter_chk #(
    .NUM_REQ(NUM_REQ), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .rd_gnt(rd_gnt), .wr_gnt(wr_gnt), .cmd_valid(cmd_valid),
    .done_valid(done_valid), .active_cnt(active_cnt),
    .err_bad_done(err_bad_done)
);

// File: tb/cmd_admit_arbiter_tb.sv
module cmd_admit_arbiter_tb;
    localparam int NR = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rd_req = '0, wr_req = '0;
    logic [NR*LW-1:0] rd_len, wr_len;
    logic [NR-1:0] rd_gnt, wr_gnt;
    logic          cmd_valid, cmd_write;
    logic [1:0]    cmd_id;
    logic [LW-1:0] cmd_len;
    logic [2:0]    cmd_slot;
    logic          done_valid = 1'b0;
    logic [2:0]    done_slot = '0;
    logic [3:0]    active_cnt;
    logic          err_bad_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    // Beat counts: read requester i asks for i+1 beats, write requester i for i+9.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            rd_len[i*LW +: LW] = LW'(i + 1);
            wr_len[i*LW +: LW] = LW'(i + 9);
        end
    end

    cmd_admit_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_len(rd_len),
        .wr_req(wr_req), .wr_len(wr_len), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt),
        .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_write(cmd_write),
        .cmd_len(cmd_len), .cmd_slot(cmd_slot), .done_valid(done_valid),
        .done_slot(done_slot), .active_cnt(active_cnt),
        .err_bad_done(err_bad_done)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic [3:0] wq;
        logic       dv;
        logic [2:0] ds;
        logic [3:0] rg;
        logic [3:0] wg;
        logic [3:0] cnt;
        logic       err;
        logic [2:0] slot;
    } step_t;

    localparam step_t STEPS[12] = '{
        '{4'b0110, 4'b0000, 1'b0, 3'd0, 4'b0010, 4'b0000, 4'd1, 1'b0, 3'd0},
        '{4'b0100, 4'b1001, 1'b0, 3'd0, 4'b0000, 4'b0001, 4'd2, 1'b0, 3'd1},
        '{4'b0100, 4'b1000, 1'b0, 3'd0, 4'b0100, 4'b0000, 4'd3, 1'b0, 3'd2},
        '{4'b0000, 4'b1000, 1'b0, 3'd0, 4'b0000, 4'b1000, 4'd4, 1'b0, 3'd3},
        '{4'b1111, 4'b0000, 1'b0, 3'd0, 4'b0001, 4'b0000, 4'd5, 1'b0, 3'd4},
        '{4'b1110, 4'b0000, 1'b0, 3'd0, 4'b0010, 4'b0000, 4'd6, 1'b0, 3'd5},
        '{4'b1100, 4'b0000, 1'b0, 3'd0, 4'b0100, 4'b0000, 4'd7, 1'b0, 3'd6},
        '{4'b1000, 4'b0010, 1'b0, 3'd0, 4'b0000, 4'b0010, 4'd8, 1'b0, 3'd7},
        '{4'b1000, 4'b0000, 1'b0, 3'd0, 4'b0000, 4'b0000, 4'd8, 1'b0, 3'd0},
        '{4'b1000, 4'b0000, 1'b1, 3'd2, 4'b1000, 4'b0000, 4'd8, 1'b0, 3'd2},
        '{4'b0000, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'b0000, 4'd7, 1'b0, 3'd0},
        '{4'b0000, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'b0000, 4'd7, 1'b1, 3'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Drive at the falling edge, read grants 1 ns later, registered results 1 ns after the rising edge.
    task automatic run_step(input step_t s);
        @(negedge clk);
        rd_req = s.rq; wr_req = s.wq; done_valid = s.dv; done_slot = s.ds;
        #1;
        chk("R1 rd_gnt", int'(rd_gnt), int'(s.rg));
        chk("R2 wr_gnt", int'(wr_gnt), int'(s.wg));
        @(posedge clk);
        #1;
        chk("R6 active_cnt", int'(active_cnt), int'(s.cnt));
        chk("R7 err_bad_done", int'(err_bad_done), int'(s.err));
        chk("R5 cmd_valid", int'(cmd_valid), int'((|s.rg) || (|s.wg)));
        if (|s.wg) begin
            chk("R5 cmd_write", int'(cmd_write), 1);
            chk("R5 cmd_id", int'(cmd_id), low_idx(s.wg));
            chk("R5 cmd_len", int'(cmd_len), low_idx(s.wg) + 9);
            chk("R5 cmd_slot", int'(cmd_slot), int'(s.slot));
        end else if (|s.rg) begin
            chk("R5 cmd_write", int'(cmd_write), 0);
            chk("R5 cmd_id", int'(cmd_id), low_idx(s.rg));
            chk("R5 cmd_len", int'(cmd_len), low_idx(s.rg) + 1);
            chk("R5 cmd_slot", int'(cmd_slot), int'(s.slot));
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        chk("R8 cnt at reset", int'(active_cnt), 0);
        chk("R8 err at reset", int'(err_bad_done), 0);
        chk("R8 cmd_valid at reset", int'(cmd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table: R1 R2 R3 R4 R5 R6 R7 in sequence
        foreach (STEPS[k]) run_step(STEPS[k]);

        // R8: reset mid-run clears count and sticky error
        @(negedge clk);
        rd_req = '0; wr_req = '0; done_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R8 cnt after reset", int'(active_cnt), 0);
        chk("R8 err after reset", int'(err_bad_done), 0);
        chk("R8 cmd_valid after reset", int'(cmd_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: read preferred first after reset, then write
        run_step('{4'b0001, 4'b0001, 1'b0, 3'd0, 4'b0001, 4'b0000, 4'd1, 1'b0, 3'd0});
        // R2: write picker favours lowest index independently
        run_step('{4'b0000, 4'b0110, 1'b0, 3'd0, 4'b0000, 4'b0010, 4'd2, 1'b0, 3'd1});
        // R6: free slot 0 while idle; next read reuses slot 0 (lowest free)
        run_step('{4'b0000, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'b0000, 4'd1, 1'b0, 3'd0});
        run_step('{4'b0100, 4'b0000, 1'b0, 3'd0, 4'b0100, 4'b0000, 4'd2, 1'b0, 3'd0});

        @(negedge clk);
        rd_req = '0; wr_req = '0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule